// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder

This block is a purely combinational 64-bit add/subtract unit. Its carry path can be cut into independent lanes, so a single evaluation handles eight byte lanes, four halfword lanes, two word lanes or one full doubleword. Three control inputs set the arithmetic:
- a subtract enable,
- a saturation enable,
- a signed/unsigned select.

Subtraction is done by inverting the second operand and injecting a one as the carry-in at the bottom of every lane.

Each lane detects its own overflow. The detection rule depends on the mode:
- Signed lanes use the operand and result sign bits.
- Unsigned lanes use the lane's carry-out, or the absence of it when subtracting.

When saturation is on, an overflowing lane is clipped to the bound it ran past. When it is off, the lane keeps the modulo result. Either way, the lane's overflow flag is reported on every byte position the lane occupies.

A media or vector datapath uses this block as its packed-integer adder. It sits between operand registers owned by the surrounding pipeline.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel` picks the lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = one 64-bit lane. Lane k covers bits [W*(k+1)-1 : W*k]. No carry or borrow passes from one lane into the next.
- R2: With `sub_en`=1 and `sat_en`=0, each lane of `result` equals a−b modulo 2^W. With `sub_en`=0 and `sat_en`=0, each lane equals a+b modulo 2^W.
- R3: With `sat_en`=0, an overflowing lane outputs the wrapped modulo value, and its overflow flag is still raised.
- R4: In signed mode (`signed_en`=1), an add overflows only when both operands share a sign and the result sign differs. A subtract overflows only when the operands differ in sign and the result sign differs from a's sign. Operands for which this rule cannot hold never raise the flag.
- R5: `ovf_flags` bit i belongs to byte i (bits 8i+7:8i). A lane's overflow flag appears on every byte bit of that lane, and only there.
- R6: In unsigned mode, an add overflows when the lane carries out of its top bit. A subtract overflows when b is greater than a in that lane (a borrow).
- R7: Signed saturation (`sat_en`=1) replaces a positive overflow with the lane maximum (0x7F followed by 0xFF bytes). It replaces a negative overflow with the lane minimum (0x80 followed by 0x00 bytes).
- R8: Unsigned saturation replaces an overflowing add with all ones and an overflowing subtract with zero.
- R9: With `sat_en`=1, a lane that does not overflow outputs exactly its modulo result, whatever the neighbouring lanes do.
- R10: With all inputs zero, `result` is zero and `ovf_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 64 | First operand, packed lanes |
| b | input | 64 | Second operand, packed lanes |
| lane_sel | input | 2 | Lane width select (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| sub_en | input | 1 | 1 = compute a−b, 0 = compute a+b |
| sat_en | input | 1 | 1 = clip overflowing lanes, 0 = wrap |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| result | output | 64 | Packed lane results |
| ovf_flags | output | 8 | Per-byte overflow flag, replicated across each lane |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the input that exposes it.

Typical faults and their symptoms:
- A carry leaking across a lane cut shows up as the neighbouring lane's result being off by one.
- A wrong lane map or a wrong flag broadcast shows up as overflow bits that differ between bytes of one lane, or that spill into another lane.
- A wrong clip direction or clip bound is visible as soon as an overflow is driven in the affected sign and mode.

The stimulus therefore pairs each lane width with operands placed exactly at the carry, borrow and sign boundaries.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
// Package: simd_pkg
// Shared constants and lane-width codes for the partitioned adder.
// Assumes the datapath is a power-of-two number of bytes.
package simd_pkg;

    localparam int BYTE_W = 8;

    // Lane width codes carried on lane_sel.
    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_mode_e;

endpackage

// File: rtl/simd_lane_map.sv
`timescale 1ns/1ps
// Module: simd_lane_map
// Marks, for each byte position, whether it opens a lane (carry-in point)
// and whether it closes a lane (sign and carry-out point).
// Assumes NBYTES is a power of two and lane_sel < $clog2(NBYTES)+1.
module simd_lane_map #(
    parameter int NBYTES = 8,
    parameter int MODE_W = 2
) (
    input  logic [MODE_W-1:0] lane_sel,
    output logic [NBYTES-1:0] lane_first,
    output logic [NBYTES-1:0] lane_last
);

    logic [31:0] lane_mask;

    // Purpose: byte-count mask of one lane minus one.
    always_comb begin
        lane_mask = (32'd1 << lane_sel) - 32'd1;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_pos
        // Purpose: boundary flags for byte g.
        always_comb begin
            lane_first[g] = ((32'(g) & lane_mask) == 32'd0);
            lane_last[g]  = ((32'(g + 1) & lane_mask) == 32'd0);
        end
    end

endmodule

// File: rtl/simd_carry_chain.sv
`timescale 1ns/1ps
// Module: simd_carry_chain
// Byte-sliced ripple adder. The carry into a byte that opens a lane is the
// lane carry-in (sub_en), otherwise the carry out of the byte below.
// For subtraction the second operand is inverted here.
module simd_carry_chain #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic              sub_en,
    input  logic [NBYTES-1:0] lane_first,
    output logic [DW-1:0]     sum_raw,
    output logic [NBYTES-1:0] byte_cout,
    output logic [NBYTES-1:0] bx_msb
);

    logic [DW-1:0]     b_eff;
    logic [NBYTES-1:0] byte_cin;

    // Purpose: conditional one's complement of the second operand.
    always_comb begin
        b_eff = sub_en ? ~b : b;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W:0] part;

        if (g == 0) begin : g_base
            // Purpose: lowest byte always takes the lane carry-in.
            always_comb byte_cin[g] = sub_en;
        end else begin : g_link
            // Purpose: cut the chain at a lane start, else ripple.
            always_comb byte_cin[g] = lane_first[g] ? sub_en : byte_cout[g-1];
        end

        // Purpose: one byte slice of the addition.
        always_comb begin
            part = {1'b0, a[g*BYTE_W +: BYTE_W]}
                 + {1'b0, b_eff[g*BYTE_W +: BYTE_W]}
                 + {{BYTE_W{1'b0}}, byte_cin[g]};
            sum_raw[g*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
            byte_cout[g] = part[BYTE_W];
            bx_msb[g]    = b_eff[g*BYTE_W + BYTE_W - 1];
        end
    end

endmodule

// File: rtl/simd_ovf_detect.sv
`timescale 1ns/1ps
// Module: simd_ovf_detect
// Computes the overflow flag and clip direction at each lane's top byte,
// then copies both onto every byte of the lane.
// Assumes NBYTES is a power of two; lane_sel selects 2^lane_sel bytes per lane.
module simd_ovf_detect #(
    parameter int NBYTES = 8,
    parameter int MODE_W = 2,
    localparam int NMODES = $clog2(NBYTES) + 1
) (
    input  logic [MODE_W-1:0] lane_sel,
    input  logic              sub_en,
    input  logic              signed_en,
    input  logic [NBYTES-1:0] lane_last,
    input  logic [NBYTES-1:0] a_msb,
    input  logic [NBYTES-1:0] bx_msb,
    input  logic [NBYTES-1:0] sum_msb,
    input  logic [NBYTES-1:0] byte_cout,
    output logic [NBYTES-1:0] ovf_byte,
    output logic [NBYTES-1:0] clip_high
);

    logic [NBYTES-1:0] top_ovf;
    logic [NBYTES-1:0] top_high;

    for (genvar g = 0; g < NBYTES; g++) begin : g_top
        // Purpose: lane overflow and clip direction, valid at lane top byte.
        always_comb begin
            if (signed_en) begin
                top_ovf[g]  = lane_last[g] & (a_msb[g] == bx_msb[g])
                                           & (sum_msb[g] != a_msb[g]);
                top_high[g] = ~a_msb[g];
            end else begin
                top_ovf[g]  = lane_last[g] & (byte_cout[g] ^ sub_en);
                top_high[g] = ~sub_en;
            end
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_bcast
        logic [NMODES-1:0] cand_ovf;
        logic [NMODES-1:0] cand_high;

        for (genvar m = 0; m < NMODES; m++) begin : g_mode
            localparam int TOP = g | ((1 << m) - 1);
            // Purpose: value this byte would inherit at lane width 2^m bytes.
            always_comb begin
                cand_ovf[m]  = top_ovf[TOP];
                cand_high[m] = top_high[TOP];
            end
        end

        // Purpose: pick the inherited flag for the active lane width.
        always_comb begin
            ovf_byte[g]  = cand_ovf[lane_sel];
            clip_high[g] = cand_high[lane_sel];
        end
    end

endmodule

// File: rtl/simd_saturate.sv
`timescale 1ns/1ps
// Module: simd_saturate
// Per-byte output select: modulo sum, or the clip bound of the lane when the
// lane overflowed and saturation is enabled.
// Signed bounds put 0x7F/0x80 in the lane top byte and 0xFF/0x00 below it.
module simd_saturate #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic [DW-1:0]     sum_raw,
    input  logic [NBYTES-1:0] ovf_byte,
    input  logic [NBYTES-1:0] clip_high,
    input  logic [NBYTES-1:0] lane_last,
    input  logic              sat_en,
    input  logic              signed_en,
    output logic [DW-1:0]     result
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] bound;

        // Purpose: clip bound for this byte of its lane.
        always_comb begin
            if (signed_en && lane_last[g]) begin
                bound = {~clip_high[g], {(BYTE_W-1){clip_high[g]}}};
            end else begin
                bound = {BYTE_W{clip_high[g]}};
            end
        end

        // Purpose: choose clipped or modulo byte.
        always_comb begin
            result[g*BYTE_W +: BYTE_W] = (sat_en && ovf_byte[g])
                                       ? bound
                                       : sum_raw[g*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
`timescale 1ns/1ps
// Module: simd_sat_adder
// Top of the lane-partitioned add/subtract unit with optional saturation.
// Purely combinational; lane_sel, sub_en, sat_en and signed_en apply to all
// lanes of the current operands.
module simd_sat_adder #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = simd_pkg::BYTE_W,
    localparam int DW     = NBYTES * BYTE_W,
    localparam int MODE_W = $clog2($clog2(NBYTES) + 1)
) (
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [MODE_W-1:0] lane_sel,
    input  logic              sub_en,
    input  logic              sat_en,
    input  logic              signed_en,
    output logic [DW-1:0]     result,
    output logic [NBYTES-1:0] ovf_flags
);

    logic [NBYTES-1:0] lane_first;
    logic [NBYTES-1:0] lane_last;
    logic [DW-1:0]     sum_raw;
    logic [NBYTES-1:0] byte_cout;
    logic [NBYTES-1:0] bx_msb;
    logic [NBYTES-1:0] a_msb;
    logic [NBYTES-1:0] sum_msb;
    logic [NBYTES-1:0] clip_high;

    // Purpose: gather per-byte sign bits of operand a and the raw sum.
    always_comb begin
        for (int g = 0; g < NBYTES; g++) begin
            a_msb[g]   = a[g*BYTE_W + BYTE_W - 1];
            sum_msb[g] = sum_raw[g*BYTE_W + BYTE_W - 1];
        end
    end

    simd_lane_map #(
        .NBYTES (NBYTES),
        .MODE_W (MODE_W)
    ) u_map (
        .lane_sel   (lane_sel),
        .lane_first (lane_first),
        .lane_last  (lane_last)
    );

    simd_carry_chain #(
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_chain (
        .a          (a),
        .b          (b),
        .sub_en     (sub_en),
        .lane_first (lane_first),
        .sum_raw    (sum_raw),
        .byte_cout  (byte_cout),
        .bx_msb     (bx_msb)
    );

    simd_ovf_detect #(
        .NBYTES (NBYTES),
        .MODE_W (MODE_W)
    ) u_ovf (
        .lane_sel  (lane_sel),
        .sub_en    (sub_en),
        .signed_en (signed_en),
        .lane_last (lane_last),
        .a_msb     (a_msb),
        .bx_msb    (bx_msb),
        .sum_msb   (sum_msb),
        .byte_cout (byte_cout),
        .ovf_byte  (ovf_flags),
        .clip_high (clip_high)
    );

    simd_saturate #(
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_sat (
        .sum_raw   (sum_raw),
        .ovf_byte  (ovf_flags),
        .clip_high (clip_high),
        .lane_last (lane_last),
        .sat_en    (sat_en),
        .signed_en (signed_en),
        .result    (result)
    );

    // Purpose: immediate checks relating ports and sub-block outputs.
    always_comb begin
        for (int g = 0; g < NBYTES; g++) begin
            // Lane-opening byte sees only the lane carry-in, nothing from below.
            if (lane_first[g]) begin
                AST_LANE_CUT: assert (sum_raw[g*BYTE_W +: BYTE_W] ==
                    BYTE_W'(a[g*BYTE_W +: BYTE_W]
                          + (sub_en ? ~b[g*BYTE_W +: BYTE_W] : b[g*BYTE_W +: BYTE_W])
                          + BYTE_W'(sub_en))); // R1
            end
            if (g < NBYTES - 1 && !lane_last[g]) begin
                AST_FLAG_UNIFORM: assert (ovf_flags[g] == ovf_flags[g+1]); // R5
            end
            if (signed_en && lane_last[g] &&
                (a[g*BYTE_W+BYTE_W-1] ^ b[g*BYTE_W+BYTE_W-1] ^ sub_en)) begin
                AST_NO_SIGNED_OVF: assert (!ovf_flags[g]); // R4
            end
            if (sat_en && !ovf_flags[g]) begin
                AST_CLEAN_LANE: assert (result[g*BYTE_W +: BYTE_W] ==
                                        sum_raw[g*BYTE_W +: BYTE_W]); // R9
            end
            if (sat_en && !signed_en && ovf_flags[g]) begin
                AST_UNSIGNED_CLIP: assert (result[g*BYTE_W +: BYTE_W] ==
                                           {BYTE_W{~sub_en}}); // R8
            end
            if (sat_en && signed_en && ovf_flags[g] && lane_last[g]) begin
                AST_SIGNED_CLIP_TOP: assert (result[g*BYTE_W +: BYTE_W] ==
                    (a[g*BYTE_W+BYTE_W-1] ? {1'b1, {(BYTE_W-1){1'b0}}}
                                          : {1'b0, {(BYTE_W-1){1'b1}}})); // R7
            end
        end
    end

endmodule

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
// Bench for simd_sat_adder: table walk against a lane-level integer model,
// then directed corner cases with literal expected values.
module simd_sat_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [1:0]  lane_sel = '0;
    logic        sub_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        signed_en = 1'b0;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #4 clk = ~clk;

    simd_sat_adder u_simd_sat_adder (
        .a         (a),
        .b         (b),
        .lane_sel  (lane_sel),
        .sub_en    (sub_en),
        .sat_en    (sat_en),
        .signed_en (signed_en),
        .result    (result),
        .ovf_flags (ovf_flags)
    );

    // Lane-level model: {flags, result}
    function automatic logic [71:0] model(input logic [63:0] xa, input logic [63:0] xb,
                                          input logic [1:0] m, input logic sb,
                                          input logic st, input logic sg);
        int w;
        int nl;
        logic [63:0] res;
        logic [7:0]  fl;
        logic [63:0] mask;
        w = 8 << m;
        nl = 64 / w;
        res = '0;
        fl = '0;
        mask = (64'd1 << w) - 64'd1;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] la;
            logic [63:0] lb;
            logic signed [66:0] va;
            logic signed [66:0] vb;
            logic signed [66:0] r;
            logic signed [66:0] mx;
            logic signed [66:0] mn;
            logic signed [66:0] o;
            logic ov;
            la = (xa >> (l * w)) & mask;
            lb = (xb >> (l * w)) & mask;
            va = $signed({3'b000, la});
            vb = $signed({3'b000, lb});
            if (sg) begin
                if (la[w-1]) va = va - (67'sd1 <<< w);
                if (lb[w-1]) vb = vb - (67'sd1 <<< w);
                mx = (67'sd1 <<< (w - 1)) - 67'sd1;
                mn = -(67'sd1 <<< (w - 1));
            end else begin
                mx = (67'sd1 <<< w) - 67'sd1;
                mn = 67'sd0;
            end
            r = sb ? (va - vb) : (va + vb);
            ov = (r > mx) || (r < mn);
            o = r;
            if (st && ov) o = (r > mx) ? mx : mn;
            res = res | ((o[63:0] & mask) << (l * w));
            if (ov) fl = fl | (8'((16'd1 << (w / 8)) - 16'd1) << (l * (w / 8)));
        end
        return {fl, res};
    endfunction

    task automatic check(input string req, input logic [63:0] er, input logic [7:0] ef);
        checks++;
        if (result !== er || ovf_flags !== ef) begin
            errors++;
            $display("FAIL %s: result %h flags %h, expected result %h flags %h",
                     req, result, ovf_flags, er, ef);
        end
    endtask

    task automatic apply(input logic [63:0] xa, input logic [63:0] xb, input logic [1:0] m,
                         input logic sb, input logic st, input logic sg);
        @(posedge clk);
        a = xa; b = xb; lane_sel = m; sub_en = sb; sat_en = st; signed_en = sg;
        @(negedge clk);
    endtask

    // {a, b, lane_sel, sub_en, sat_en, signed_en}
    localparam logic [132:0] VEC [14] = '{
        {64'h7F80_01FF_40C0_8001, 64'h0180_FF01_40C0_807F, 2'd0, 1'b0, 1'b1, 1'b1},
        {64'h7F80_01FF_40C0_8001, 64'h0180_FF01_40C0_807F, 2'd0, 1'b0, 1'b0, 1'b1},
        {64'h7F80_01FF_40C0_8001, 64'h0180_FF01_40C0_807F, 2'd0, 1'b1, 1'b1, 1'b1},
        {64'h7F80_01FF_40C0_8001, 64'h0180_FF01_40C0_807F, 2'd0, 1'b0, 1'b1, 1'b0},
        {64'h7F80_01FF_40C0_8001, 64'h0180_FF01_40C0_807F, 2'd0, 1'b1, 1'b1, 1'b0},
        {64'h7FFF_8000_FFFF_1234, 64'h0001_FFFF_0001_EDCC, 2'd1, 1'b0, 1'b1, 1'b1},
        {64'h7FFF_8000_FFFF_1234, 64'h0001_FFFF_0001_EDCC, 2'd1, 1'b1, 1'b0, 1'b1},
        {64'h7FFF_8000_FFFF_1234, 64'h0001_FFFF_0001_EDCC, 2'd1, 1'b0, 1'b1, 1'b0},
        {64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'd2, 1'b0, 1'b1, 1'b1},
        {64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'd2, 1'b1, 1'b1, 1'b0},
        {64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'd2, 1'b0, 1'b0, 1'b0},
        {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b1, 1'b1},
        {64'h0000_0000_0000_0005, 64'h0000_0000_0000_0009, 2'd3, 1'b1, 1'b1, 1'b0},
        {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 2'd1, 1'b1, 1'b0, 1'b0}
    };

    // Watchdog: an expired run counts as a failed check and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 100000) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: cycles %0d, expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: all-zero inputs while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 zero inputs", 64'h0, 8'h00);
        rst_n = 1'b1;

        // Table walk (R1 R2 R3 R4 R6 R7 R8 R9 across modes)
        for (int i = 0; i < 14; i++) begin
            logic [71:0] exp_v;
            apply(VEC[i][132:69], VEC[i][68:5], VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
            exp_v = model(VEC[i][132:69], VEC[i][68:5], VEC[i][4:3],
                          VEC[i][2], VEC[i][1], VEC[i][0]);
            check($sformatf("R9 table[%0d]", i), exp_v[63:0], exp_v[71:64]);
        end

        // R7 positive and negative signed clip, byte lanes
        apply(64'h7F, 64'h01, 2'd0, 1'b0, 1'b1, 1'b1);
        check("R7 pos clip", 64'h7F, 8'h01);
        apply(64'h80, 64'hFF, 2'd0, 1'b0, 1'b1, 1'b1);
        check("R7 neg clip", 64'h80, 8'h01);
        apply(64'h00, 64'h80, 2'd0, 1'b1, 1'b1, 1'b1);
        check("R7 zero minus min", 64'h7F, 8'h01);

        // R8 / R3 unsigned add carry-out
        apply(64'hFF, 64'h01, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R8 add clip", 64'hFF, 8'h01);
        apply(64'hFF, 64'h01, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R3 add wrap", 64'h00, 8'h01);

        // R8 / R2 unsigned borrow
        apply(64'h05, 64'h07, 2'd0, 1'b1, 1'b1, 1'b0);
        check("R8 sub clip", 64'h00, 8'h01);
        apply(64'h05, 64'h07, 2'd0, 1'b1, 1'b0, 1'b0);
        check("R2 sub wrap", 64'hFE, 8'h01);

        // R1 carry crosses inside a 16-bit lane, is cut between 8-bit lanes
        apply(64'h00FF, 64'h0001, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R1 16-bit carry", 64'h0100, 8'h00);
        apply(64'h00FF, 64'h0001, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R1 8-bit cut", 64'h0000, 8'h01);

        // R6 / R1 borrow inside vs across lanes
        apply(64'h0100, 64'h0001, 2'd1, 1'b1, 1'b0, 1'b0);
        check("R6 16-bit no borrow", 64'h00FF, 8'h00);
        apply(64'h0100, 64'h0001, 2'd0, 1'b1, 1'b0, 1'b0);
        check("R6 8-bit borrow", 64'h01FF, 8'h01);

        // R4 opposite-sign add never overflows; neg minus pos does
        apply(64'h7F, 64'h80, 2'd0, 1'b0, 1'b0, 1'b1);
        check("R4 opposite signs", 64'hFF, 8'h00);
        apply(64'h80, 64'h01, 2'd0, 1'b1, 1'b0, 1'b1);
        check("R4 sub wrap", 64'h7F, 8'h01);
        apply(64'h80, 64'h01, 2'd0, 1'b1, 1'b1, 1'b1);
        check("R7 sub clip", 64'h80, 8'h01);

        // R5 flag broadcast over a full 64-bit lane and an upper 32-bit lane
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R5 64-bit lane", 64'h0, 8'hFF);
        apply(64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 1'b1, 1'b1);
        check("R5 upper 32-bit lane", 64'h7FFF_FFFF_0000_0001, 8'hF0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule